// File: doc/BRIEF.md
# Multi-Source Reset Pulse Generator

This block gathers every cause that may reset a board and turns them into one active-high reset line for attached devices plus a strobe that resets the chip core. A power-on event or a watchdog underflow starts a timed pulse. The pulse length is counted in frame-sync periods and not in system clocks, so it follows the frame rate. With an 8 kHz frame sync the default of 8 periods gives 1 ms.

An external reset pin is followed directly. Its assertion reaches the output with no clock in the path. Its release goes through a synchroniser and waits for the next bit-clock rising edge. A software hold bit drives the device reset line for as long as it is set and leaves the core alone. Software can therefore hold attached devices in reset while the chip keeps clocking them.

The frame-sync and bit-clock edges arrive as single-cycle enable strobes in the system clock domain. The block's own synchronous reset clears all of its state.

Top module: `rst_pulse_gen`

## Requirements
- R1: After `sys_rst`, with `pin_rst`, `sw_hold`, `por_evt` and `wdt_uflow` all low, both `dev_rst` and `core_rst` are 0.
- R2: A cycle with `por_evt` high raises `dev_rst` and `core_rst` from the next clock edge. Both stay high until the clock edge that samples the 8th `frame_tick` after the event, and drop after that edge.
- R3: A cycle with `wdt_uflow` high produces the same 8-frame pulse on `dev_rst` and `core_rst` as a power-on event.
- R4: A power-on or watchdog event during a running pulse restarts the count from zero. The pulse then ends on the 8th `frame_tick` after the newest event.
- R5: `pin_rst` high drives `dev_rst` high in the same cycle, with no clock edge in between.
- R6: After `pin_rst` falls, `dev_rst` stays high through the two synchroniser stages. It falls after the first clock edge that samples `bit_tick` high once the synchronised pin is low. A `bit_tick` sampled before that point does not release it.
- R7: The external pin and the software hold never raise `core_rst`.
- R8: `sw_hold` high drives `dev_rst` high. Clearing it releases `dev_rst` with no delay when no other source is active.
- R9: `frame_tick` and `bit_tick` strobes while no source is active leave both outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset of the block's state |
| frame_tick | input | 1 | One-cycle strobe per frame-sync period |
| bit_tick | input | 1 | One-cycle strobe per bit-clock rising edge |
| por_evt | input | 1 | Power-on reset event, one cycle |
| wdt_uflow | input | 1 | Watchdog underflow event, one cycle |
| pin_rst | input | 1 | External reset pin, active high, asynchronous |
| sw_hold | input | 1 | Software reset hold bit |
| dev_rst | output | 1 | Reset output to attached devices, active high |
| core_rst | output | 1 | Internal chip reset, active high |

## Verification
The timed pulse is started by a power-on event and by a watchdog event, each followed by sparse frame strobes. Checking the output just before and just after the eighth strobe shows that the pulse counts frames rather than clocks, and catches an off-by-one limit. A second event in the middle of a pulse shows whether the counter restarts or runs on. The pin case places a bit strobe inside the synchroniser latency and then a later one, which separates an early release from a correct one. The software case and the idle strobes confirm that `core_rst` stays low and that stray strobes do nothing.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  // Which reset causes are currently holding the device line.
  typedef struct packed {
    logic timed;   // power-on / watchdog frame-counted pulse
    logic pin;     // external pin, including its aligned release
    logic sw;      // software hold
  } rst_src_t;

  function automatic logic any_src(input rst_src_t s);
    return s.timed | s.pin | s.sw;
  endfunction
endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rpg_pulse_timer.sv
module rpg_pulse_timer #(
  parameter int PULSE_FRAMES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic frame_tick,
  output logic active
);
  localparam int CNT_W = (PULSE_FRAMES > 1) ? $clog2(PULSE_FRAMES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && frame_tick) begin
      if (cnt_q == LAST) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active = act_q;

  assert_start_raises_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> act_q);
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  assert_idle_cnt_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> cnt_q == '0);
  assert_ends_on_last_R2: assert property (@(posedge clk) disable iff (rst)
    (act_q && frame_tick && cnt_q == LAST && !start) |=> !act_q);
  assert_no_tick_no_end_R4: assert property (@(posedge clk) disable iff (rst)
    (act_q && !frame_tick) |=> act_q);
endmodule

// File: rtl/rpg_pin_follow.sv
module rpg_pin_follow #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  input  logic bit_tick,
  output logic active
);
  logic pin_sync;
  logic hold_q;

  rpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_sync)
  );

  // Held while the synchronised pin is high; released on a bit strobe after.
  always_ff @(posedge clk) begin
    if (rst)            hold_q <= 1'b0;
    else if (pin_sync)  hold_q <= 1'b1;
    else if (bit_tick)  hold_q <= 1'b0;
  end

  // Assertion path is combinational from the pin itself.
  assign active = pin_raw | hold_q;

  assert_release_on_bit_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> $past(bit_tick));
  assert_no_release_while_synced_R6: assert property (@(posedge clk) disable iff (rst)
    pin_sync |=> hold_q);
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int PULSE_FRAMES = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic frame_tick,
  input  logic bit_tick,
  input  logic por_evt,
  input  logic wdt_uflow,
  input  logic pin_rst,
  input  logic sw_hold,
  output logic dev_rst,
  output logic core_rst
);
  import rpg_pkg::*;

  rst_src_t src;
  logic     timed_act;
  logic     pin_act;

  rpg_pulse_timer #(.PULSE_FRAMES(PULSE_FRAMES)) u_timer (
    .clk        (clk),
    .rst        (sys_rst),
    .start      (por_evt | wdt_uflow),
    .frame_tick (frame_tick),
    .active     (timed_act)
  );

  rpg_pin_follow #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk      (clk),
    .rst      (sys_rst),
    .pin_raw  (pin_rst),
    .bit_tick (bit_tick),
    .active   (pin_act)
  );

  always_comb begin
    src.timed = timed_act;
    src.pin   = pin_act;
    src.sw    = sw_hold;
  end

  assign dev_rst  = any_src(src);
  assign core_rst = timed_act;

  assert_pin_immediate_R5: assert property (@(posedge clk) disable iff (sys_rst)
    pin_rst |-> dev_rst);
  assert_sw_drives_R8: assert property (@(posedge clk) disable iff (sys_rst)
    sw_hold |-> dev_rst);
  assert_core_implies_dev_R7: assert property (@(posedge clk) disable iff (sys_rst)
    core_rst |-> dev_rst);
  assert_event_core_R3: assert property (@(posedge clk) disable iff (sys_rst)
    (por_evt || wdt_uflow) |=> core_rst);
endmodule

// File: tb/test_rst_pulse_gen.sv
module test_rst_pulse_gen;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic sys_rst, frame_tick, bit_tick, por_evt, wdt_uflow, pin_rst, sw_hold;
  logic dev_rst, core_rst;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_pulse_gen i_rst_pulse_gen (
    .clk(clk), .sys_rst(sys_rst), .frame_tick(frame_tick), .bit_tick(bit_tick),
    .por_evt(por_evt), .wdt_uflow(wdt_uflow), .pin_rst(pin_rst),
    .sw_hold(sw_hold), .dev_rst(dev_rst), .core_rst(core_rst)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One frame strobe, sampled at the following rising edge.
  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      idle(3);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    sys_rst = 1'b1;
    idle(3);
    sys_rst = 1'b0;
    @(negedge clk);
    check("R1 dev_rst", dev_rst, 1'b0);
    check("R1 core_rst", core_rst, 1'b0);
  endtask

  task automatic t_idle_strobes;
    for (int i = 0; i < 4; i++) begin
      frame_tick = 1'b1; bit_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0; bit_tick = 1'b0;
      @(negedge clk);
    end
    check("R9 dev_rst", dev_rst, 1'b0);
    check("R9 core_rst", core_rst, 1'b0);
  endtask

  task automatic t_timed(input string req, input bit use_wdt);
    if (use_wdt) wdt_uflow = 1'b1; else por_evt = 1'b1;
    @(negedge clk);
    wdt_uflow = 1'b0; por_evt = 1'b0;
    check({req, " dev start"}, dev_rst, 1'b1);
    check({req, " core start"}, core_rst, 1'b1);
    frames(7);
    check({req, " dev after 7"}, dev_rst, 1'b1);
    check({req, " core after 7"}, core_rst, 1'b1);
    frames(1);
    check({req, " dev after 8"}, dev_rst, 1'b0);
    check({req, " core after 8"}, core_rst, 1'b0);
  endtask

  task automatic t_restart;
    por_evt = 1'b1;
    @(negedge clk);
    por_evt = 1'b0;
    frames(5);
    wdt_uflow = 1'b1;
    @(negedge clk);
    wdt_uflow = 1'b0;
    frames(7);
    check("R4 still high after 12", dev_rst, 1'b1);
    check("R4 core still high", core_rst, 1'b1);
    frames(1);
    check("R4 released after 8 since restart", dev_rst, 1'b0);
  endtask

  task automatic t_pin;
    pin_rst = 1'b1;
    #1;
    check("R5 immediate", dev_rst, 1'b1);
    idle(5);
    check("R7 pin core", core_rst, 1'b0);
    pin_rst = 1'b0;
    #1;
    check("R6 held after pin low", dev_rst, 1'b1);
    @(negedge clk);
    bit_tick = 1'b1;          // sampled while synchroniser still high
    @(negedge clk);
    bit_tick = 1'b0;
    idle(4);
    check("R6 early bit ignored", dev_rst, 1'b1);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    check("R6 released on bit", dev_rst, 1'b0);
    check("R7 pin core after", core_rst, 1'b0);
  endtask

  task automatic t_sw;
    sw_hold = 1'b1;
    #1;
    check("R8 sw drives", dev_rst, 1'b1);
    idle(3);
    check("R7 sw core", core_rst, 1'b0);
    frames(2);
    check("R8 sw still held", dev_rst, 1'b1);
    sw_hold = 1'b0;
    #1;
    check("R8 sw release", dev_rst, 1'b0);
  endtask

  initial begin
    sys_rst = 1'b1; frame_tick = 1'b0; bit_tick = 1'b0; por_evt = 1'b0;
    wdt_uflow = 1'b0; pin_rst = 1'b0; sw_hold = 1'b0;
    t_reset_state();
    t_idle_strobes();
    t_timed("R2", 1'b0);
    t_timed("R3", 1'b1);
    t_restart();
    t_pin();
    t_sw();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule